// File: doc/BRIEF.md
# Interleaved Bank Request Arbiter

This block sits between four memory requestors and a field of thirty-two independently cycling memory banks. The requestors are a port shared by the peripheral processors, one port for each of two central processors, and a port for extended memory. In every clock cycle (one issue slot) the arbiter may place one request on a broadcast bus. The request carries a word address, a write flag and the index of the requestor. Every bank sees the bus. The bank selected by the low address bits answers with an accept pulse one cycle later, but only if that bank is not still in the middle of an earlier cycle.

The arbiter keeps no record of which banks are busy. It issues without looking and then reads the accept line in the following cycle. If the accept comes, the requestor gets a one-cycle done pulse and may present new work. If no accept comes, the requestor is parked for a fixed back-off, and the same request then competes for a slot again. Slots are granted by fixed priority. Banks hold 16K words each. With the default parameters the address is 19 bits wide, and bits [4:0] select the bank, so consecutive words fall in consecutive banks.

Top module: `rb_bank_arbiter`

## Requirements
- R1: While reset is high, and in the first cycle after it, `bus_valid` is 0 and `req_done` is all zero.
- R2: `bus_valid` is high only when the requestor named by `bus_src` was asserting `req_valid` in the previous cycle. With no requestor asserting, nothing is issued.
- R3: Among the eligible requestors the lowest index wins the slot: index 0 (peripheral group) first, then 1, then 2, then 3 (extended memory).
- R4: An issued request carries the winner's address and write flag unchanged, and `bus_src` is the winner's index. The bank is taken from address bits [BANK_W-1:0].
- R5: An idle requestor that asserts `req_valid` in cycle t, and wins, appears on the bus in cycle t+1.
- R6: `bus_accept` is read in the cycle after an issue. If it is high, `req_done` of the issuing requestor pulses in that same cycle and no other done bit is set.
- R7: A rejected request is issued again no sooner than RETRY_GAP (default 4) slots after its previous issue. It is issued at exactly that distance when nothing of higher priority contends.
- R8: A requestor whose request is on the bus, awaiting its accept, or backing off is never granted a slot.
- R9: A requestor that keeps asserting its request is eventually accepted once its bank frees. Every request leads to exactly one done pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one issue slot per cycle |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | NREQ | Per-requestor request, held until its done pulse |
| req_addr | input | NREQ*AW | Per-requestor word address, requestor i in bits [i*AW +: AW] |
| req_write | input | NREQ | Per-requestor write flag |
| req_done | output | NREQ | One-cycle pulse when the request was accepted |
| bus_valid | output | 1 | Broadcast request present in this slot |
| bus_addr | output | AW | Broadcast word address |
| bus_write | output | 1 | Broadcast write flag |
| bus_src | output | SW | Index of the issuing requestor |
| bus_accept | input | 1 | Accept pulse from the addressed bank, one cycle after issue |

## Verification
Suppose a requestor's state goes wrong, for example it leaves back-off early or never leaves the check state. The port shows this within a few cycles. The retry lands closer than four slots to the previous issue, the same requestor appears on two consecutive slots, or a done pulse comes without a matching accept and never comes with one. A corrupted grant shows on the very next slot as the wrong `bus_src` or the wrong address for the queued request. A lost request shows as a requestor whose done count falls short of its request count at the end of the run.

// File: rtl/rb_pkg.sv
package rb_pkg;

    localparam int NUM_REQ    = 4;
    localparam int NUM_BANKS  = 32;
    localparam int BANK_W     = $clog2(NUM_BANKS);
    localparam int BANK_WORDS = 16384;
    localparam int ADDR_W     = BANK_W + $clog2(BANK_WORDS);
    localparam int BANK_BUSY  = 10;
    localparam int RETRY_GAP  = 4;

    typedef enum logic [1:0] {
        SL_IDLE,
        SL_ISSUE,
        SL_CHECK,
        SL_BACKOFF
    } slot_state_e;

    function automatic logic [BANK_W-1:0] bank_of(input logic [ADDR_W-1:0] a);
        return a[BANK_W-1:0];
    endfunction

endpackage

// File: rtl/rb_req_slot.sv
module rb_req_slot
    import rb_pkg::*;
#(
    parameter int RETRY = RETRY_GAP
) (
    input  logic clk,
    input  logic rst,
    input  logic req_valid,
    input  logic grant,
    input  logic ack_in,
    output logic eligible,
    output logic in_check,
    output logic done
);
    localparam int BO_CYC = (RETRY > 3) ? RETRY - 3 : 1;
    localparam int CW     = $clog2(RETRY + 1);

    slot_state_e     state;
    logic [CW-1:0]   bo_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= SL_IDLE;
            bo_cnt <= '0;
        end else begin
            case (state)
                SL_IDLE:    if (grant) state <= SL_ISSUE;
                SL_ISSUE:   state <= SL_CHECK;
                SL_CHECK: begin
                    if (ack_in) begin
                        state <= SL_IDLE;
                    end else begin
                        state  <= SL_BACKOFF;
                        bo_cnt <= CW'(BO_CYC - 1);
                    end
                end
                SL_BACKOFF: begin
                    if (bo_cnt == '0) state <= SL_IDLE;
                    else              bo_cnt <= bo_cnt - 1'b1;
                end
                default:    state <= SL_IDLE;
            endcase
        end
    end

    assign eligible = (state == SL_IDLE) && req_valid;
    assign in_check = (state == SL_CHECK);
    assign done     = in_check && ack_in;

    a_r8_no_grant_busy: assert property (@(posedge clk) disable iff (rst)
        grant |-> (state == SL_IDLE && req_valid));
    a_r7_reject_backs_off: assert property (@(posedge clk) disable iff (rst)
        (state == SL_CHECK && !ack_in) |=> (state == SL_BACKOFF && !grant));
    a_r6_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

endmodule

// File: rtl/rb_prio_pick.sv
module rb_prio_pick #(
    parameter int N  = 4,
    parameter int SW = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [N-1:0]  elig,
    output logic [N-1:0]  grant,
    output logic          any,
    output logic [SW-1:0] idx
);
    always_comb begin
        grant = '0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (elig[i]) begin
                grant    = '0;
                grant[i] = 1'b1;
                idx      = SW'(i);
            end
        end
        any = |elig;
    end

    a_r3_fixed_prio: assert property (@(posedge clk) disable iff (rst)
        ((grant - 1'b1) & grant & elig) == '0 && (grant & elig) == grant);
    a_r3_onehot: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant));
    a_r2_slot_used: assert property (@(posedge clk) disable iff (rst)
        (|elig) |-> (|grant));

endmodule

// File: rtl/rb_bank_arbiter.sv
module rb_bank_arbiter
    import rb_pkg::*;
#(
    parameter int NREQ  = NUM_REQ,
    parameter int AW    = ADDR_W,
    parameter int RETRY = RETRY_GAP,
    parameter int SW    = (NREQ > 1) ? $clog2(NREQ) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NREQ-1:0]    req_valid,
    input  logic [NREQ*AW-1:0] req_addr,
    input  logic [NREQ-1:0]    req_write,
    output logic [NREQ-1:0]    req_done,
    output logic               bus_valid,
    output logic [AW-1:0]      bus_addr,
    output logic               bus_write,
    output logic [SW-1:0]      bus_src,
    input  logic               bus_accept
);
    typedef struct packed {
        logic          valid;
        logic          wr;
        logic [SW-1:0] src;
        logic [AW-1:0] addr;
    } issue_t;

    logic [NREQ-1:0] elig;
    logic [NREQ-1:0] grant;
    logic [NREQ-1:0] in_check;
    logic            any;
    logic [SW-1:0]   win;
    issue_t          iss_q;

    for (genvar g = 0; g < NREQ; g++) begin : g_slot
        rb_req_slot #(.RETRY(RETRY)) u_slot (
            .clk       (clk),
            .rst       (rst),
            .req_valid (req_valid[g]),
            .grant     (grant[g]),
            .ack_in    (bus_accept),
            .eligible  (elig[g]),
            .in_check  (in_check[g]),
            .done      (req_done[g])
        );
    end

    rb_prio_pick #(.N(NREQ), .SW(SW)) u_pick (
        .clk   (clk),
        .rst   (rst),
        .elig  (elig),
        .grant (grant),
        .any   (any),
        .idx   (win)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            iss_q <= '0;
        end else begin
            iss_q.valid <= any;
            if (any) begin
                iss_q.src  <= win;
                iss_q.wr   <= req_write[win];
                iss_q.addr <= req_addr[win*AW +: AW];
            end
        end
    end

    assign bus_valid = iss_q.valid;
    assign bus_addr  = iss_q.addr;
    assign bus_write = iss_q.wr;
    assign bus_src   = iss_q.src;

    a_r2_no_idle_issue: assert property (@(posedge clk) disable iff (rst)
        (req_valid == '0) |=> !bus_valid);
    a_r5_next_slot: assert property (@(posedge clk) disable iff (rst)
        (elig != '0) |=> bus_valid);
    a_r6_done_follows_issue: assert property (@(posedge clk) disable iff (rst)
        (req_done != '0) |-> ($past(bus_valid) && bus_accept));
    a_r6_done_onehot: assert property (@(posedge clk) disable iff (rst)
        $onehot0(req_done) && $onehot0(in_check));
    a_r8_no_back_to_back: assert property (@(posedge clk) disable iff (rst)
        bus_valid |=> !(bus_valid && bus_src == $past(bus_src)));

endmodule

// File: tb/rb_bank_arbiter_tb.sv
module rb_bank_arbiter_tb;
    import rb_pkg::*;

    localparam int NR = NUM_REQ;
    localparam int AW = ADDR_W;
    localparam int SW = $clog2(NUM_REQ);

    typedef struct {
        logic [AW-1:0] a;
        logic          w;
    } exp_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [NR-1:0]    req_valid = '0;
    logic [NR*AW-1:0] req_addr  = '0;
    logic [NR-1:0]    req_write = '0;
    logic [NR-1:0]    req_done;
    logic             bus_valid;
    logic [AW-1:0]    bus_addr;
    logic             bus_write;
    logic [SW-1:0]    bus_src;
    logic             bus_accept;

    always #5 clk = ~clk;

    rb_bank_arbiter u_dut (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_addr(req_addr), .req_write(req_write),
        .req_done(req_done),
        .bus_valid(bus_valid), .bus_addr(bus_addr), .bus_write(bus_write),
        .bus_src(bus_src), .bus_accept(bus_accept)
    );

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit finished = 0;
    bit exact = 0;
    int n_retry = 0;
    exp_t q[NR][$];
    int log_src[$];
    int log_cyc[$];
    int start_cyc[NR];
    int done_cyc[NR];
    int n_sent[NR];
    int n_done[NR];
    bit rej[NR];
    int rej_cyc[NR];
    bit p_valid = 0;
    int p_src = 0;
    int p_cyc = 0;
    int bcnt[NUM_BANKS];

    task automatic chk(input string tag, input longint act, input longint expv);
        checks++;
        if (act != expv) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
        end
    endtask

    always @(posedge clk) cyc <= cyc + 1;

    // bank field model: a bank accepts only with no cycle in progress
    always @(posedge clk) begin
        if (rst) begin
            bus_accept <= 1'b0;
            for (int b = 0; b < NUM_BANKS; b++) bcnt[b] <= 0;
        end else begin
            bus_accept <= 1'b0;
            for (int b = 0; b < NUM_BANKS; b++)
                if (bcnt[b] > 0) bcnt[b] <= bcnt[b] - 1;
            if (bus_valid && bcnt[bank_of(bus_addr)] == 0) begin
                bus_accept <= 1'b1;
                bcnt[bank_of(bus_addr)] <= BANK_BUSY - 1;
            end
        end
    end

    // monitor: compares bus and done activity against the scoreboard
    always @(negedge clk) begin
        logic [NR-1:0] exp_done;
        int s;
        if (rst) begin
            p_valid = 0;
            for (int i = 0; i < NR; i++) rej[i] = 0;
        end else begin
            exp_done = (p_valid && bus_accept) ? NR'(1 << p_src) : '0;
            chk("R6 done pulse", req_done, exp_done);
            if (p_valid && !bus_accept) begin
                rej[p_src] = 1;
                rej_cyc[p_src] = p_cyc;
            end
            for (int i = 0; i < NR; i++) begin
                if (req_done[i]) begin
                    rej[i] = 0;
                    n_done[i]++;
                    if (q[i].size() == 0) chk("R9 done without request", 1, 0);
                    else void'(q[i].pop_front());
                end
            end
            if (bus_valid) begin
                s = int'(bus_src);
                chk("R2 issuer was requesting", req_valid[s], 1);
                chk("R8 reissued while in flight", (p_valid && p_src == s), 0);
                if (q[s].size() == 0) begin
                    chk("R4 issue with empty queue", 1, 0);
                end else begin
                    chk("R4 address", bus_addr, q[s][0].a);
                    chk("R4 write flag", bus_write, q[s][0].w);
                end
                if (rej[s]) begin
                    n_retry++;
                    if (exact) chk("R7 retry gap", cyc - rej_cyc[s], RETRY_GAP);
                    else       chk("R7 retry gap minimum", (cyc - rej_cyc[s]) >= RETRY_GAP, 1);
                end
                log_src.push_back(s);
                log_cyc.push_back(cyc);
            end
            p_valid = bus_valid;
            p_src   = int'(bus_src);
            p_cyc   = cyc;
        end
    end

    task automatic send(input int i, input logic [AW-1:0] a, input logic w);
        exp_t e;
        @(negedge clk);
        req_valid[i] = 1'b1;
        req_addr[i*AW +: AW] = a;
        req_write[i] = w;
        e.a = a;
        e.w = w;
        q[i].push_back(e);
        n_sent[i]++;
        start_cyc[i] = cyc;
        do @(negedge clk); while (!req_done[i]);
        done_cyc[i] = cyc;
        req_valid[i] = 1'b0;
    endtask

    task automatic rand_stream(input int i, input int n);
        for (int k = 0; k < n; k++) begin
            logic [AW-1:0] a;
            a = AW'($urandom);
            a[BANK_W-1:0] = BANK_W'($urandom_range(0, 5));
            send(i, a, 1'($urandom));
        end
    endtask

    function automatic logic [AW-1:0] mk(input int bank, input int row);
        return AW'((row << BANK_W) | bank);
    endfunction

    initial begin
        for (int i = 0; i < NR; i++) begin
            n_sent[i] = 0;
            n_done[i] = 0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 bus idle in reset", bus_valid, 0);
        chk("R1 done idle in reset", req_done, 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 bus idle after reset", bus_valid, 0);
        chk("R1 done idle after reset", req_done, 0);

        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            chk("R2 no issue when idle", bus_valid, 0);
        end

        // R5 single request latency
        log_src.delete(); log_cyc.delete();
        send(2, mk(5, 77), 1'b1);
        chk("R5 one issue", log_src.size(), 1);
        chk("R5 issue source", log_src[0], 2);
        chk("R5 issue latency", log_cyc[0] - start_cyc[2], 1);
        chk("R6 done latency", done_cyc[2] - start_cyc[2], 2);
        repeat (12) @(negedge clk);

        // R3 fixed priority with all four contending
        log_src.delete(); log_cyc.delete();
        fork
            send(0, mk(8, 1), 1'b0);
            send(1, mk(9, 2), 1'b1);
            send(2, mk(10, 3), 1'b0);
            send(3, mk(11, 4), 1'b1);
        join
        chk("R3 issue count", log_src.size(), 4);
        for (int k = 0; k < 4; k++) begin
            chk("R3 priority order", log_src[k], k);
            chk("R3 slot timing", log_cyc[k] - start_cyc[0], k + 1);
        end
        repeat (12) @(negedge clk);

        // R7 retry spacing against a busy bank, R9 eventual acceptance
        exact = 1;
        n_retry = 0;
        fork
            send(1, mk(3, 9), 1'b1);
            begin
                @(negedge clk);
                send(0, mk(3, 5), 1'b0);
            end
        join
        exact = 0;
        chk("R7 retry count", n_retry, 3);
        chk("R9 accepted after bank frees", done_cyc[0] - start_cyc[0], 14);
        repeat (12) @(negedge clk);

        // mixed traffic with bank conflicts
        fork
            rand_stream(0, 30);
            rand_stream(1, 30);
            rand_stream(2, 30);
            rand_stream(3, 30);
        join
        repeat (4) @(negedge clk);
        for (int i = 0; i < NR; i++) begin
            chk("R9 every request completed", n_done[i], n_sent[i]);
            chk("R9 scoreboard drained", q[i].size(), 0);
        end

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule